// File: doc/BRIEF.md
# RGB to Composite Video Encoder

This block turns one low-depth RGB pixel into the 7-bit word that drives an external resistor-ladder DAC, producing a composite baseband video level. Each colour channel carries two bits, giving 64 colours. The colour is mapped arithmetically to a luma value and two signed colour-difference values. Each colour-difference value is then modulated by a square-wave carrier bit: it is added when the bit is high and subtracted when it is low. The two modulated values are added to the luma and to the black pedestal, and the result is registered onto the output.

A timing generator upstream supplies a sync flag, a blanking flag, the in-phase and quadrature carrier bits, a standard select and a line-parity bit. Sync forces the lowest code. Blanking forces the black pedestal. In PAL mode the quadrature component changes sign on alternate lines. Black sits at code 16 and white at code 48. The codes from 0 to 15 below black and from 49 to 63 above white leave room for the chroma swing.

Top module: `cvbs_encoder`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `dac_code` is 0 after that edge.
- R2: When `sync` is 1, `dac_code` is 0 one clock later. Sync has priority over blanking and ignores the pixel and carrier inputs.
- R3: When `sync` is 0 and `blank` is 1, `dac_code` is 16 one clock later. The pixel and carrier inputs have no effect.
- R4: The pixel uses red = `rgb[5:4]`, green = `rgb[3:2]` and blue = `rgb[1:0]`. Luma is floor((19R + 38G + 7B) / 6), which ranges from 0 for black to 32 for white.
- R5: With S = 19R + 38G + 7B, U = (64B − S)/16 and V = (64R − S)/12, both divided with truncation toward zero. Every grey pixel (R = G = B) therefore has U = V = 0.
- R6: During active video (`sync` = 0, `blank` = 0), `dac_code` one clock later equals 16 + luma + (`car_i` ? U : −U) + (`car_q` ? Vq : −Vq), clamped to the range 0..127. Black gives 16 and white gives 48.
- R7: Vq is −V when `std_pal` = 1 and `line_odd` = 1, and V otherwise. In NTSC mode (`std_pal` = 0), `line_odd` has no effect.
- R8: For every input combination, `dac_code` stays at or below 63, so bit 6 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rgb | input | 6 | Pixel colour: red [5:4], green [3:2], blue [1:0] |
| sync | input | 1 | Sync tip request |
| blank | input | 1 | Blanking interval (black pedestal, no chroma) |
| car_i | input | 1 | In-phase carrier square wave |
| car_q | input | 1 | Quadrature carrier square wave |
| std_pal | input | 1 | 1 selects PAL line alternation, 0 selects NTSC |
| line_odd | input | 1 | Line parity used for PAL alternation |
| dac_code | output | 7 | Registered ladder DAC code |

## Verification
The bench sweeps all 64 colours against all four carrier phases, both standards and both line parities. This exposes a wrong sign on either carrier (saturated colours land on the mirror-image code), a PAL flip that fires in NTSC or on the wrong parity, and floor division in place of truncation on negative colour differences (an off-by-one on colours such as yellow and blue). Grey pixels under all four carrier phases catch residual chroma, which would make white swing away from 48. Sync and blank are asserted over every colour, with sync and blank both high, to catch leaked chroma, wrong priority and a mis-set pedestal.

// File: rtl/cvbs_pkg.sv
// Shared widths and the colour-space record for the composite encoder.
// Assumes two bits per colour channel; the arithmetic map is sized for it.
package cvbs_pkg;
    localparam int CH_W   = 2;            // bits per colour channel
    localparam int PIX_W  = 3 * CH_W;     // packed pixel width
    localparam int Y_W    = 6;            // luma width, 0..32
    localparam int C_W    = 6;            // signed colour-difference width
    localparam int CHR_W  = C_W + 1;      // signed modulated chroma width
    localparam int DAC_W  = 7;            // ladder resolution

    typedef struct packed {
        logic        [Y_W-1:0] luma;
        logic signed [C_W-1:0] u;
        logic signed [C_W-1:0] v;
    } yuv_t;
endpackage

// File: rtl/cvbs_yuv_lut.sv
// Colour map: turns a 2-bit-per-channel RGB pixel into luma and two signed
// colour differences. The table is computed, not stored; greys carry no chroma.
// Assumes the channel weights below (they sum to 64, so white maps to 32).
module cvbs_yuv_lut
    import cvbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] rgb,
    output yuv_t             yuv
);
    localparam int W_R = 19;
    localparam int W_G = 38;
    localparam int W_B = 7;
    localparam int Y_DIV = 6;
    localparam int U_DIV = 16;
    localparam int V_DIV = 12;

    logic [CH_W-1:0] red, grn, blu;
    int ysum, yq, uq, vq;

    assign red = rgb[3*CH_W-1:2*CH_W];
    assign grn = rgb[2*CH_W-1:CH_W];
    assign blu = rgb[CH_W-1:0];

    // Weighted sum and truncating divisions for the three components.
    always_comb begin
        ysum = W_R * int'(red) + W_G * int'(grn) + W_B * int'(blu);
        yq   = ysum / Y_DIV;
        uq   = (64 * int'(blu) - ysum) / U_DIV;
        vq   = (64 * int'(red) - ysum) / V_DIV;
        yuv.luma = yq[Y_W-1:0];
        yuv.u    = uq[C_W-1:0];
        yuv.v    = vq[C_W-1:0];
    end

    // R5: a grey pixel must map to zero colour difference.
    a_r5_grey_no_chroma: assert property (@(posedge clk) disable iff (!rst_n)
        (red == grn && grn == blu) |-> (yuv.u == '0 && yuv.v == '0));

    // R4: luma never passes the white excursion.
    a_r4_luma_range: assert property (@(posedge clk) disable iff (!rst_n)
        yuv.luma <= Y_W'(32));
endmodule

// File: rtl/cvbs_chroma_mod.sv
// Square-wave modulator: adds or subtracts each colour difference according
// to its carrier bit, with optional sign flip of the quadrature term.
// Assumes a zero result is wanted whenever enable is low (sync or blanking).
module cvbs_chroma_mod
    import cvbs_pkg::*;
(
    input  logic                    enable,
    input  logic                    car_i,
    input  logic                    car_q,
    input  logic                    flip_q,
    input  logic signed [C_W-1:0]   u,
    input  logic signed [C_W-1:0]   v,
    output logic signed [CHR_W-1:0] chroma
);
    logic signed [CHR_W-1:0] u_x, v_x, u_m, v_m;

    // Sign-extend the inputs and apply the line alternation to V.
    always_comb begin
        u_x = CHR_W'(u);
        v_x = flip_q ? -CHR_W'(v) : CHR_W'(v);
    end

    // Carrier bit high adds the term, low subtracts it; gated during blanking.
    always_comb begin
        u_m    = car_i ? u_x : -u_x;
        v_m    = car_q ? v_x : -v_x;
        chroma = enable ? (u_m + v_m) : '0;
    end
endmodule

// File: rtl/cvbs_level_sum.sv
// Output stage: picks sync, pedestal or pedestal+luma+chroma, clamps the
// sum to the ladder range and registers it.
// Assumes chroma is already zero outside active video.
module cvbs_level_sum
    import cvbs_pkg::*;
#(
    parameter int BLACK_LVL = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync,
    input  logic                    blank,
    input  logic [Y_W-1:0]          luma,
    input  logic signed [CHR_W-1:0] chroma,
    output logic [DAC_W-1:0]        dac_code
);
    localparam int CODE_MAX = (1 << DAC_W) - 1;

    int total;
    logic [DAC_W-1:0] level;

    // Form the composite sum and clamp it into the DAC range.
    always_comb begin
        total = BLACK_LVL + int'(luma) + int'(chroma);
        if (sync)
            level = '0;
        else if (blank)
            level = DAC_W'(BLACK_LVL);
        else if (total < 0)
            level = '0;
        else if (total > CODE_MAX)
            level = DAC_W'(CODE_MAX);
        else
            level = total[DAC_W-1:0];
    end

    // Register the code; reset holds the line at the sync level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_code <= '0;
        else
            dac_code <= level;
    end
endmodule

// File: rtl/cvbs_encoder.sv
// Composite encoder top: colour map, square-wave chroma modulator and
// registered level summer. One clock from inputs to dac_code.
// Assumes carrier bits and line parity come from an external timing source.
module cvbs_encoder
    import cvbs_pkg::*;
#(
    parameter int BLACK_LVL   = 16,
    parameter bit PAL_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] rgb,
    input  logic             sync,
    input  logic             blank,
    input  logic             car_i,
    input  logic             car_q,
    input  logic             std_pal,
    input  logic             line_odd,
    output logic [DAC_W-1:0] dac_code
);
    yuv_t                    yuv;
    logic                    flip_q;
    logic                    active;
    logic signed [CHR_W-1:0] chroma;

    assign active = !sync && !blank;

    // Quadrature alternation exists only when PAL support is built in.
    generate
        if (PAL_SUPPORT) begin : g_pal
            assign flip_q = std_pal & line_odd;
        end else begin : g_ntsc_only
            assign flip_q = 1'b0;
        end
    endgenerate

    cvbs_yuv_lut u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .rgb   (rgb),
        .yuv   (yuv)
    );

    cvbs_chroma_mod u_mod (
        .enable (active),
        .car_i  (car_i),
        .car_q  (car_q),
        .flip_q (flip_q),
        .u      (yuv.u),
        .v      (yuv.v),
        .chroma (chroma)
    );

    cvbs_level_sum #(.BLACK_LVL(BLACK_LVL)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (sync),
        .blank    (blank),
        .luma     (yuv.luma),
        .chroma   (chroma),
        .dac_code (dac_code)
    );

    // R1: reset drives the sync level on the next edge.
    a_r1_reset_sync_level: assert property (@(posedge clk)
        !rst_n |=> dac_code == '0);

    // R2: a sync request yields code zero one clock later.
    a_r2_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> dac_code == '0);

    // R3: blanking without sync yields the pedestal one clock later.
    a_r3_blank_pedestal: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && blank) |=> dac_code == DAC_W'(BLACK_LVL));

    // R8: the top bit of the code is never used.
    a_r8_headroom: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code <= DAC_W'(63));
endmodule

// File: tb/sim_cvbs_encoder.sv
// Self-checking sweep of the composite encoder.
module sim_cvbs_encoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] rgb;
    logic       sync, blank, car_i, car_q, std_pal, line_odd;
    logic [6:0] dac_code;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cvbs_encoder u0 (
        .clk(clk), .rst_n(rst_n), .rgb(rgb), .sync(sync), .blank(blank),
        .car_i(car_i), .car_q(car_q), .std_pal(std_pal), .line_odd(line_odd),
        .dac_code(dac_code)
    );

    // Expected active-video code from the stated formulas (R4..R7).
    function automatic int expect_code(int r, int g, int b, bit ci, bit cq,
                                       bit pal, bit odd);
        int s, y, u, v, c;
        s = 19 * r + 38 * g + 7 * b;
        y = s / 6;
        u = (64 * b - s) / 16;
        v = (64 * r - s) / 12;
        if (pal && odd) v = -v;
        c = 16 + y + (ci ? u : -u) + (cq ? v : -v);
        if (c < 0) c = 0;
        if (c > 127) c = 127;
        return c;
    endfunction

    task automatic check(string req, int exp_v);
        n_chk++;
        if (int'(dac_code) != exp_v) begin
            n_fail++;
            $display("FAIL %s: dac_code=%0d expected=%0d (rgb=%b sync=%b blank=%b i=%b q=%b pal=%b odd=%b)",
                     req, dac_code, exp_v, rgb, sync, blank, car_i, car_q, std_pal, line_odd);
        end
    endtask

    // Drive at the falling edge, let one rising edge register, sample at the next fall.
    task automatic apply(logic [5:0] px, bit s, bit bl, bit ci, bit cq,
                         bit pal, bit odd);
        rgb = px; sync = s; blank = bl; car_i = ci; car_q = cq;
        std_pal = pal; line_odd = odd;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rgb = 6'h3f; sync = 0; blank = 0; car_i = 1; car_q = 1;
        std_pal = 0; line_odd = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1", 0);                       // reset state while pixel is white
        rst_n = 1'b1;

        // R4 R5 R6 R7 R8: full sweep of colours, phases, standards, parities.
        for (int pal = 0; pal < 2; pal++)
            for (int odd = 0; odd < 2; odd++)
                for (int ph = 0; ph < 4; ph++)
                    for (int px = 0; px < 64; px++) begin
                        apply(6'(px), 0, 0, ph[0], ph[1], pal[0], odd[0]);
                        check("R6", expect_code(px / 16, (px / 4) % 4, px % 4,
                                                ph[0], ph[1], pal[0], odd[0]));
                        if (dac_code > 7'd63) check("R8", 63);
                    end

        // R4 R5: explicit greys and anchors under every carrier phase.
        for (int ph = 0; ph < 4; ph++) begin
            apply(6'h00, 0, 0, ph[0], ph[1], 1, 1); check("R4 black", 16);
            apply(6'h3f, 0, 0, ph[0], ph[1], 1, 1); check("R4 white", 48);
            apply(6'h15, 0, 0, ph[0], ph[1], 0, 0); check("R5 grey1", 26);
            apply(6'h2a, 0, 0, ph[0], ph[1], 0, 1); check("R5 grey2", 37);
        end

        // R7: NTSC ignores parity; PAL flips V on odd lines (pure red).
        apply(6'h30, 0, 0, 1, 1, 0, 1);
        check("R7 ntsc", expect_code(3, 0, 0, 1, 1, 0, 0));
        apply(6'h30, 0, 0, 1, 1, 1, 1);
        check("R7 pal odd", expect_code(3, 0, 0, 1, 1, 0, 0) - 2 * 11);

        // R2 R3: sync and blank over every colour and phase.
        for (int px = 0; px < 64; px++) begin
            apply(6'(px), 1, 0, px[0], px[1], px[2], px[3]); check("R2", 0);
            apply(6'(px), 1, 1, px[1], px[0], px[3], px[2]); check("R2 priority", 0);
            apply(6'(px), 0, 1, px[0], px[1], px[2], px[3]); check("R3", 16);
        end

        // R1: reset again from an active white level.
        apply(6'h3f, 0, 0, 1, 1, 0, 0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reassert", 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule